// File: doc/BRIEF.md
# Two-Port FIFO and Mailbox Access Controller

This block sits between two synchronous host ports and a pair of opposite-direction FIFOs plus a pair of single-word mailbox registers. On every rising clock edge each port decodes its select, direction, enable and mailbox-select lines. From them it picks one action: push into its outgoing FIFO, deposit a word in its outgoing mailbox, pop from its incoming FIFO, take the word from its incoming mailbox, or nothing. The FIFO storage is external. The block issues the push and pop strobes, forwards the write data and returns read data through a per-port output mux.

Each mailbox has an active-low full flag. A deposit sets the flag low, and taking the word on the far port sets it high again. While the flag shows full, further deposits are dropped. Port A treats a high direction line as "write". Port B uses the opposite sense. Each port's data-bus output enable is raised only when that port is selected and its direction is "read".

Top module: `bidir_mbox_ctrl`

## Requirements
- R1: A port's `*_oe` is high exactly when its `*_cs_n` is low and its direction line selects read. For port A, read is `a_wr_rd`=0. For port B, read is `b_wr_rd`=1.
- R2: A FIFO push strobe (`f1_wr` from A, `f2_wr` from B) is high only when all of these hold: select low, direction write, enable high, mailbox select low, and the FIFO's `*_full_n` high. The pushed data equals that port's data input.
- R3: A mailbox deposit on an edge where the mailbox flag is high (empty) drives the flag low on that edge. The far port then reads the deposited word.
- R4: A deposit while the mailbox flag is low is dropped: the stored word and the flag are unchanged.
- R5: A FIFO pop strobe (`f2_rd` for A, `f1_rd` for B) is high only when all of these hold: select low, direction read, enable high, mailbox select low, and the FIFO's `*_empty_n` high.
- R6: With select low, direction read, enable high and mailbox select high, an edge drives the incoming mailbox flag high. In read direction the port's data output carries the incoming mailbox word when mailbox select is 1, and the incoming FIFO data when it is 0.
- R7: With enable low, no strobe is issued and no mailbox flag or word changes, whatever the direction and mailbox select.
- R8: Port B's direction sense is opposite to port A's: `b_wr_rd`=0 pushes into FIFO 2 or deposits into mailbox 2.
- R9: While reset is held, and for two edges after it is released, no strobe is issued. Both mailbox flags read 1 and both mailbox words read 0.
- R10: A deposit and a take of the same mailbox on one edge leave the mailbox full with the new word if it was empty before. If it was full before, they leave it empty with the old word kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr_rd | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A operation enable |
| a_mb_sel | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data |
| a_oe | output | 1 | Port A bus output enable |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr_rd | input | 1 | Port B direction: 0 write, 1 read |
| b_en | input | 1 | Port B operation enable |
| b_mb_sel | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data |
| b_oe | output | 1 | Port B bus output enable |
| f1_full_n | input | 1 | FIFO 1 (A to B) can accept a word |
| f1_empty_n | input | 1 | FIFO 1 holds a word |
| f1_rdata | input | DATA_W | FIFO 1 head word |
| f1_wr | output | 1 | FIFO 1 push strobe |
| f1_wdata | output | DATA_W | FIFO 1 push data |
| f1_rd | output | 1 | FIFO 1 pop strobe |
| f2_full_n | input | 1 | FIFO 2 (B to A) can accept a word |
| f2_empty_n | input | 1 | FIFO 2 holds a word |
| f2_rdata | input | DATA_W | FIFO 2 head word |
| f2_wr | output | 1 | FIFO 2 push strobe |
| f2_wdata | output | DATA_W | FIFO 2 push data |
| f2_rd | output | 1 | FIFO 2 pop strobe |
| mb1_full_n | output | 1 | Mailbox 1 (A to B) flag, low when holding a word |
| mb2_full_n | output | 1 | Mailbox 2 (B to A) flag, low when holding a word |

## Verification
The hardest case to reach is two ports hitting the same mailbox on one edge. A deposit on one side must meet a take on the other, once with the mailbox already full and once with it empty. The outcome is visible only through the flag and the far port's read mux afterwards. The bench first fills the mailbox, then drives both ports in the same cycle. It inspects the word through the far port with enable low, so that looking does not disturb the state. The full decode table is swept on each port with the lines restored before the clock edge, so the sweep never changes the mailboxes.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_FIFO_WR = 3'd1,
    ACT_MB_WR   = 3'd2,
    ACT_FIFO_RD = 3'd3,
    ACT_MB_RD   = 3'd4
  } port_act_e;
endpackage

// File: rtl/bpc_rst_sync.sv
module bpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bpc_port_decode.sv
module bpc_port_decode
  import bpc_pkg::*;
#(
  parameter bit WR_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cs_n,
  input  logic wr_rd,
  input  logic en,
  input  logic mb_sel,
  input  logic in_ready,
  input  logic out_ready,
  output logic fifo_wr,
  output logic mb_wr,
  output logic fifo_rd,
  output logic mb_rd,
  output logic bus_oe
);
  port_act_e act;
  logic      dir_in;

  generate
    if (WR_HIGH) begin : g_pol_hi
      assign dir_in = wr_rd;
    end else begin : g_pol_lo
      assign dir_in = ~wr_rd;
    end
  endgenerate

  always_comb begin
    act = ACT_NONE;
    if (run && !cs_n && en) begin
      if (dir_in) begin
        if (mb_sel)        act = ACT_MB_WR;
        else if (in_ready) act = ACT_FIFO_WR;
      end else begin
        if (mb_sel)         act = ACT_MB_RD;
        else if (out_ready) act = ACT_FIFO_RD;
      end
    end
  end

  always_comb begin
    fifo_wr = (act == ACT_FIFO_WR);
    mb_wr   = (act == ACT_MB_WR);
    fifo_rd = (act == ACT_FIFO_RD);
    mb_rd   = (act == ACT_MB_RD);
    bus_oe  = !cs_n && !dir_in;
  end

  // R7
  no_act_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(fifo_wr || mb_wr || fifo_rd || mb_rd));
  // R2
  push_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (in_ready && !mb_sel));
  // R5
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (out_ready && !mb_sel));
  // R1
  no_write_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !(fifo_wr || mb_wr));
  // R7
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr, mb_wr, fifo_rd, mb_rd}));
endmodule

// File: rtl/bpc_mailbox.sv
module bpc_mailbox #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              full_n
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              flag_q, flag_d;
  logic              wr_acc;
  logic              upd_en;

  always_comb begin
    wr_acc = wr_req && flag_q;
    upd_en = wr_acc || rd_req;
    data_d = data_q;
    flag_d = flag_q;
    if (wr_acc) begin
      data_d = wdata;
      flag_d = 1'b0;
    end else if (rd_req) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b1;
    end else if (upd_en) begin
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  assign rdata  = data_q;
  assign full_n = flag_q;

  // R3
  deposit_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full_n) |=> (!full_n && rdata == $past(wdata)));
  // R4
  deposit_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !full_n) |=> $stable(rdata));
  // R6
  take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !(wr_req && full_n)) |=> full_n);
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !rd_req) |=> ($stable(rdata) && $stable(full_n)));
endmodule

// File: rtl/bidir_mbox_ctrl.sv
module bidir_mbox_ctrl #(
  parameter int DATA_W     = 36,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_wr_rd,
  input  logic              a_en,
  input  logic              a_mb_sel,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  input  logic              b_cs_n,
  input  logic              b_wr_rd,
  input  logic              b_en,
  input  logic              b_mb_sel,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  input  logic              f1_full_n,
  input  logic              f1_empty_n,
  input  logic [DATA_W-1:0] f1_rdata,
  output logic              f1_wr,
  output logic [DATA_W-1:0] f1_wdata,
  output logic              f1_rd,
  input  logic              f2_full_n,
  input  logic              f2_empty_n,
  input  logic [DATA_W-1:0] f2_rdata,
  output logic              f2_wr,
  output logic [DATA_W-1:0] f2_wdata,
  output logic              f2_rd,
  output logic              mb1_full_n,
  output logic              mb2_full_n
);
  logic              srst_n;
  logic              a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;
  logic [DATA_W-1:0] mb1_q, mb2_q;

  bpc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bpc_port_decode #(.WR_HIGH(1'b1)) u_dec_a (
    .clk       (clk),
    .rst_n     (srst_n),
    .run       (srst_n),
    .cs_n      (a_cs_n),
    .wr_rd     (a_wr_rd),
    .en        (a_en),
    .mb_sel    (a_mb_sel),
    .in_ready  (f1_full_n),
    .out_ready (f2_empty_n),
    .fifo_wr   (f1_wr),
    .mb_wr     (a_mb_wr),
    .fifo_rd   (f2_rd),
    .mb_rd     (a_mb_rd),
    .bus_oe    (a_oe)
  );

  bpc_port_decode #(.WR_HIGH(1'b0)) u_dec_b (
    .clk       (clk),
    .rst_n     (srst_n),
    .run       (srst_n),
    .cs_n      (b_cs_n),
    .wr_rd     (b_wr_rd),
    .en        (b_en),
    .mb_sel    (b_mb_sel),
    .in_ready  (f2_full_n),
    .out_ready (f1_empty_n),
    .fifo_wr   (f2_wr),
    .mb_wr     (b_mb_wr),
    .fifo_rd   (f1_rd),
    .mb_rd     (b_mb_rd),
    .bus_oe    (b_oe)
  );

  bpc_mailbox #(.DATA_W(DATA_W)) u_mb1 (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_req (a_mb_wr),
    .rd_req (b_mb_rd),
    .wdata  (a_din),
    .rdata  (mb1_q),
    .full_n (mb1_full_n)
  );

  bpc_mailbox #(.DATA_W(DATA_W)) u_mb2 (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_req (b_mb_wr),
    .rd_req (a_mb_rd),
    .wdata  (b_din),
    .rdata  (mb2_q),
    .full_n (mb2_full_n)
  );

  always_comb begin
    f1_wdata = a_din;
    f2_wdata = b_din;
    a_dout   = a_mb_sel ? mb2_q : f2_rdata;
    b_dout   = b_mb_sel ? mb1_q : f1_rdata;
  end

  // R9
  quiet_in_reset_chk: assert property (@(posedge clk)
    !srst_n |-> !(f1_wr || f1_rd || f2_wr || f2_rd));
  // R10
  mb1_take_wins_when_full_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (a_mb_wr && b_mb_rd && !mb1_full_n) |=> (mb1_full_n && $stable(mb1_q)));
endmodule

// File: tb/tb_bidir_mbox_ctrl.sv
`timescale 1ns/100ps
module tb_bidir_mbox_ctrl;
  localparam int W = 36;
  logic clk = 1'b0;
  logic rst_n;
  logic a_cs_n, a_wr_rd, a_en, a_mb_sel, b_cs_n, b_wr_rd, b_en, b_mb_sel;
  logic [W-1:0] a_din, b_din, a_dout, b_dout, f1_rdata, f2_rdata, f1_wdata, f2_wdata;
  logic a_oe, b_oe, f1_full_n, f1_empty_n, f2_full_n, f2_empty_n;
  logic f1_wr, f1_rd, f2_wr, f2_rd, mb1_full_n, mb2_full_n;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bidir_mbox_ctrl #(.DATA_W(W)) dut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_cs_n = 1; a_wr_rd = 0; a_en = 0; a_mb_sel = 0;
    b_cs_n = 1; b_wr_rd = 0; b_en = 0; b_mb_sel = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  // view mailbox 1 through port B, mailbox 2 through port A, enable low
  task automatic view();
    a_cs_n = 0; a_wr_rd = 0; a_en = 0; a_mb_sel = 1;
    b_cs_n = 0; b_wr_rd = 1; b_en = 0; b_mb_sel = 1;
    #0.2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle();
    a_din = '0; b_din = '0; f1_rdata = '0; f2_rdata = '0;
    f1_full_n = 1; f1_empty_n = 1; f2_full_n = 1; f2_empty_n = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: push request during reset is suppressed
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; #1;
    chk("R9 push in reset", W'(f1_wr), W'(0));
    idle();
    rst_n = 1;
    @(negedge clk); #1;
    chk("R9 quiet after release", W'({f1_wr, f1_rd, f2_wr, f2_rd}), W'(0));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 flags", W'({mb1_full_n, mb2_full_n}), W'(2'b11));

    // decode sweep on each port (R1 R2 R5 R6 R7 R8), restored before edge
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 64; i++) begin
        logic cs, wr, en, mb, inr, outr, dir_in, ok;
        logic [W-1:0] pat;
        logic [4:0] exp_v, got_v;
        @(negedge clk);
        {cs, wr, en, mb, inr, outr} = i[5:0];
        pat = {4'h5, 26'(i * 977 + 13), 6'(i)};
        if (p == 0) begin
          a_cs_n = cs; a_wr_rd = wr; a_en = en; a_mb_sel = mb;
          f1_full_n = inr; f2_empty_n = outr; f2_rdata = pat; a_din = ~pat;
          dir_in = wr;
        end else begin
          b_cs_n = cs; b_wr_rd = wr; b_en = en; b_mb_sel = mb;
          f2_full_n = inr; f1_empty_n = outr; f1_rdata = pat; b_din = ~pat;
          dir_in = !wr;
        end
        #1;
        ok = !cs && en;
        exp_v = {ok && dir_in && !mb && inr, ok && !dir_in && !mb && outr,
                 !cs && !dir_in, 2'b00};
        if (p == 0) got_v = {f1_wr, f2_rd, a_oe, f2_wr, f1_rd};
        else        got_v = {f2_wr, f1_rd, b_oe, f1_wr, f2_rd};
        chk(p == 0 ? "R1/R2/R5/R7 port A decode" : "R1/R2/R5/R7/R8 port B decode",
            W'(got_v), W'(exp_v));
        if (p == 0) begin
          chk("R6 port A mux", a_dout, mb ? W'(0) : pat);
          chk("R2 port A push data", f1_wdata, ~pat);
        end else begin
          chk("R6 port B mux", b_dout, mb ? W'(0) : pat);
          chk("R2 port B push data", f2_wdata, ~pat);
        end
        idle();
        f1_full_n = 1; f1_empty_n = 1; f2_full_n = 1; f2_empty_n = 1;
      end
    end
    @(negedge clk); #1;
    chk("R7 sweep left mailboxes empty", W'({mb1_full_n, mb2_full_n}), W'(2'b11));

    // R3 deposit into mailbox 1
    @(negedge clk);
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb_sel = 1; a_din = 36'h1_2345_6789;
    step();
    chk("R3 mb1 flag", W'(mb1_full_n), W'(0));
    view();
    chk("R3 mb1 word", b_dout, 36'h1_2345_6789);
    step();
    chk("R7 view with enable low keeps flag", W'(mb1_full_n), W'(0));

    // R4 deposit while full is dropped
    @(negedge clk);
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb_sel = 1; a_din = 36'hA_BCDE_F012;
    step();
    view();
    chk("R4 word kept", b_dout, 36'h1_2345_6789);
    chk("R4 flag kept", W'(mb1_full_n), W'(0));

    // R6 take from mailbox 1 on B
    @(negedge clk);
    b_cs_n = 0; b_wr_rd = 1; b_en = 1; b_mb_sel = 1;
    step();
    chk("R6 mb1 emptied", W'(mb1_full_n), W'(1));

    // R8 B deposits with direction low, A takes
    @(negedge clk);
    b_cs_n = 0; b_wr_rd = 0; b_en = 1; b_mb_sel = 1; b_din = 36'h3_3333_CCCC;
    step();
    chk("R8 mb2 flag", W'(mb2_full_n), W'(0));
    view();
    chk("R8 mb2 word via A", a_dout, 36'h3_3333_CCCC);
    @(negedge clk);
    a_cs_n = 0; a_wr_rd = 0; a_en = 1; a_mb_sel = 1;
    step();
    chk("R6 mb2 emptied", W'(mb2_full_n), W'(1));

    // R10 same-edge deposit and take
    @(negedge clk);
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb_sel = 1; a_din = 36'h0_0000_D4D4;
    step();
    @(negedge clk);
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb_sel = 1; a_din = 36'h0_0000_D5D5;
    b_cs_n = 0; b_wr_rd = 1; b_en = 1; b_mb_sel = 1;
    step();
    chk("R10 full case flag", W'(mb1_full_n), W'(1));
    view();
    chk("R10 full case word", b_dout, 36'h0_0000_D4D4);
    @(negedge clk);
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb_sel = 1; a_din = 36'h0_0000_D6D6;
    b_cs_n = 0; b_wr_rd = 1; b_en = 1; b_mb_sel = 1;
    step();
    chk("R10 empty case flag", W'(mb1_full_n), W'(0));
    view();
    chk("R10 empty case word", b_dout, 36'h0_0000_D6D6);
    idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule